// File: doc/BRIEF.md
# Processor Clock Divider with Hazard-Free Ratio Switching

This block derives the processor clock from a fast source clock. A 3-bit code picks one of eight division ratios: 1, 2, 4, 8, 16, 32, 128 or 256. The set is deliberately non-uniform, so there is no divide-by-64. The divided clock comes out on `clk_div`. A one-cycle `clk_en` pulse marks the start of every divided period, so logic that runs on the source clock can act once per processor cycle.

A configuration write loads a new code at any time, while the divider keeps running. The code is held as pending and takes over only at a source edge where the old and the new divided periods both end. All ratios are cut from one shared free-running counter, so this alignment costs no extra counters. As a result, the output never shows a shortened high or low phase. Divide-by-1 passes the source clock through an AND-OR select whose control changes only at rising source edges.

Top module: `cpu_clk_div`

## Requirements
- R1: While `rst_n` is low, `clk_en` is low and `clk_div` follows the source clock. After reset the active code is 0 (ratio 1): `clk_div` equals the source clock and `clk_en` is high in every source cycle.
- R2: Code c selects ratio 2^c for c = 0..5, code 6 selects 128 and code 7 selects 256. Divide-by-64 cannot be selected.
- R3: Let e number the rising source edges since reset release, starting at 1. For an active ratio N of 2 or more, `clk_div` is high in the source cycle after edge e when (e mod N) < N/2, and low otherwise.
- R4: `clk_en` is high in the source cycle after edge e exactly when e mod N = 0. This gives one pulse per divided period, which coincides with the first high cycle of `clk_div`.
- R5: When `cfg_wr` is high at edge w, the code on `cfg_sel` becomes pending. It turns active at the first edge e > w where e is a multiple of both the old ratio and the pending ratio. Until that edge the old waveform continues unchanged.
- R6: Every high or low phase of `clk_div` is a complete phase of either the old or the new ratio. No phase is ever shorter than half the period of the faster of the two.
- R7: A second write that arrives before a pending code takes effect replaces that code. The replaced code never reaches the output.
- R8: While `cfg_wr` is low, changes on `cfg_sel` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the ratio code |
| cfg_sel | input | SEL_W (3) | Ratio code |
| clk_div | output | 1 | Divided processor clock |
| clk_en | output | 1 | One-source-cycle pulse at the start of each divided period |

## Verification
The bench drives every ordered pair of distinct codes. Each switch therefore has to wait for the joint alignment of the two periods. A divider that switched at once, or at the new period's boundary only, would leave a clipped phase, and the half-cycle phase-length monitor would flag it. Every source cycle is compared against a model that counts edges, so a switch one cycle early or late shows up as a misplaced `clk_en` or `clk_div` value. Two further directed cases cover the corners: a write landing on a pending code must discard that code, which a design with a queue or with first-write-wins would get wrong; and select activity without a strobe must leave the running ratio untouched.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

   // Map a ratio code to the counter tap it uses; tap positions at or above
   // skip are shifted up by one so that one power of two is left out.
   function automatic int tap_of(input int code, input int skip);
      return (code < skip) ? code : code + 1;
   endfunction

   // Length of one phase, in source cycles, for a given tap (0 for the pass-through).
   function automatic int half_len(input int tap);
      return (tap == 0) ? 0 : (1 << (tap - 1));
   endfunction

endpackage

// File: rtl/cdiv_counter.sv
module cdiv_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt_nxt
);

   logic [CNT_W-1:0] cnt_q;

   assign cnt_nxt = cnt_q + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end

endmodule

// File: rtl/cdiv_sel_ctrl.sv
module cdiv_sel_ctrl #(
   parameter int SEL_W    = 3,
   parameter int CNT_W    = 8,
   parameter int SKIP_TAP = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [CNT_W-1:0] cnt_nxt,
   output logic [SEL_W-1:0] act_q,
   output logic [SEL_W-1:0] act_d
);

   localparam int NUM_SEL = 1 << SEL_W;

   logic [CNT_W-1:0] mask [NUM_SEL];
   logic             pend_q;
   logic [SEL_W-1:0] pend_sel_q;
   logic [SEL_W-1:0] act_sel_q;
   logic             aligned;
   logic             apply;

   // Low-order counter bits that must all be zero at a period boundary.
   for (genvar g = 0; g < NUM_SEL; g++) begin : g_mask
      localparam int TAP = cdiv_pkg::tap_of(g, SKIP_TAP);
      assign mask[g] = CNT_W'((64'd1 << TAP) - 64'd1);
   end

   assign aligned = ((cnt_nxt & (mask[act_sel_q] | mask[pend_sel_q])) == '0);
   assign apply   = pend_q && aligned;
   assign act_d   = apply ? pend_sel_q : act_sel_q;
   assign act_q   = act_sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         pend_sel_q <= '0;
         act_sel_q  <= '0;
      end else begin
         act_sel_q <= act_d;
         pend_q    <= wr_en | (pend_q & ~apply);
         if (wr_en) pend_sel_q <= wr_sel;
      end
   end

endmodule

// File: rtl/cdiv_phase_gen.sv
module cdiv_phase_gen #(
   parameter int SEL_W    = 3,
   parameter int CNT_W    = 8,
   parameter int SKIP_TAP = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic [SEL_W-1:0] sel_nxt,
   output logic             src_q,
   output logic             ph_q,
   output logic             en_q
);

   localparam int NUM_SEL = 1 << SEL_W;

   logic [NUM_SEL-1:0] hi_bit;
   logic [NUM_SEL-1:0] start;
   logic [NUM_SEL-1:0] is_src;

   for (genvar g = 0; g < NUM_SEL; g++) begin : g_tap
      localparam int TAP = cdiv_pkg::tap_of(g, SKIP_TAP);
      if (TAP == 0) begin : g_pass
         assign hi_bit[g] = 1'b0;
         assign start[g]  = 1'b1;
         assign is_src[g] = 1'b1;
      end else begin : g_div
         assign hi_bit[g] = ~cnt_nxt[TAP-1];
         assign start[g]  = (cnt_nxt[TAP-1:0] == '0);
         assign is_src[g] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= 1'b1;
         ph_q  <= 1'b0;
         en_q  <= 1'b0;
      end else begin
         src_q <= is_src[sel_nxt];
         ph_q  <= hi_bit[sel_nxt];
         en_q  <= start[sel_nxt];
      end
   end

endmodule

// File: rtl/cdiv_clk_mux.sv
module cdiv_clk_mux (
   input  logic clk_in,
   input  logic use_src,
   input  logic ph,
   output logic clk_out
);

   // AND-OR form: the select only moves at a rising source edge while the
   // divided phase register is low, so neither leg can produce a runt.
   assign clk_out = (use_src & clk_in) | (~use_src & ph);

endmodule

// File: rtl/cpu_clk_div.sv
module cpu_clk_div #(
   parameter int SEL_W    = 3,
   parameter int CNT_W    = 8,
   parameter int SKIP_TAP = 6
) (
   input  logic             clk_src,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [SEL_W-1:0] cfg_sel,
   output logic             clk_div,
   output logic             clk_en
);

   localparam int MAX_TAP = cdiv_pkg::tap_of((1 << SEL_W) - 1, SKIP_TAP);

   if (SEL_W < 1) begin : g_bad_sel
      $error("SEL_W must be at least 1");
   end
   if (CNT_W < MAX_TAP) begin : g_bad_cnt
      $error("CNT_W too narrow for the largest ratio");
   end
   if (SKIP_TAP < 1) begin : g_bad_skip
      $error("SKIP_TAP must leave the pass-through ratio in place");
   end

   logic [CNT_W-1:0] cnt_nxt;
   logic [SEL_W-1:0] act_sel_q;
   logic [SEL_W-1:0] act_sel_d;
   logic             src_q;
   logic             ph_q;

   cdiv_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk_src),
      .rst_n   (rst_n),
      .cnt_nxt (cnt_nxt)
   );

   cdiv_sel_ctrl #(.SEL_W(SEL_W), .CNT_W(CNT_W), .SKIP_TAP(SKIP_TAP)) u_sel (
      .clk     (clk_src),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr),
      .wr_sel  (cfg_sel),
      .cnt_nxt (cnt_nxt),
      .act_q   (act_sel_q),
      .act_d   (act_sel_d)
   );

   cdiv_phase_gen #(.SEL_W(SEL_W), .CNT_W(CNT_W), .SKIP_TAP(SKIP_TAP)) u_ph (
      .clk     (clk_src),
      .rst_n   (rst_n),
      .cnt_nxt (cnt_nxt),
      .sel_nxt (act_sel_d),
      .src_q   (src_q),
      .ph_q    (ph_q),
      .en_q    (clk_en)
   );

   cdiv_clk_mux u_mux (
      .clk_in  (clk_src),
      .use_src (src_q),
      .ph      (ph_q),
      .clk_out (clk_div)
   );

endmodule

// File: rtl/cpu_clk_div_chk.sv
module cpu_clk_div_chk #(
   parameter int SEL_W    = 3,
   parameter int SKIP_TAP = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clk_en,
   input logic             src_q,
   input logic             ph_q,
   input logic [SEL_W-1:0] act_sel
);

   logic        armed;
   logic        ph_d;
   logic        src_d;
   logic        seg_ok;
   logic [15:0] run;
   logic [15:0] hlen;

   // Track the length of each divided phase and the length it should have.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed  <= 1'b0;
         ph_d   <= 1'b0;
         src_d  <= 1'b1;
         seg_ok <= 1'b0;
         run    <= '0;
         hlen   <= '0;
      end else begin
         armed <= 1'b1;
         ph_d  <= ph_q;
         src_d <= src_q;
         if ((ph_q != ph_d) || (src_q != src_d)) begin
            run    <= 16'd1;
            hlen   <= 16'(cdiv_pkg::half_len(cdiv_pkg::tap_of(int'(act_sel), SKIP_TAP)));
            seg_ok <= !src_q;
         end else if (run != 16'hFFFF) begin
            run <= run + 16'd1;
         end
      end
   end

   // R1: in pass-through mode every source cycle carries an enable
   p_src_en_r1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      src_q |-> clk_en);

   // R4: the enable pulse only ever falls in a high divided phase
   p_en_high_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (clk_en && !src_q) |-> ph_q);

   // R5: a newly applied divided ratio starts with a fresh high phase and a pulse
   p_apply_start_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (!src_q && (act_sel != $past(act_sel))) |-> (ph_q && clk_en));

   // R3 and R6: every finished divided phase has the full length of its ratio
   p_full_phase_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (!src_q && !src_d && (ph_q != ph_d) && seg_ok) |-> (run == hlen));

endmodule

bind cpu_clk_div cpu_clk_div_chk #(.SEL_W(SEL_W), .SKIP_TAP(SKIP_TAP)) i_chk (
   .clk     (clk_src),
   .rst_n   (rst_n),
   .clk_en  (clk_en),
   .src_q   (src_q),
   .ph_q    (ph_q),
   .act_sel (act_sel_q)
);

// File: tb/test_cpu_clk_div.sv
module test_cpu_clk_div;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [2:0] cfg_sel = 3'd0;
   logic       clk_div;
   logic       clk_en;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   cpu_clk_div i_cpu_clk_div (
      .clk_src (clk),
      .rst_n   (rst_n),
      .cfg_wr  (cfg_wr),
      .cfg_sel (cfg_sel),
      .clk_div (clk_div),
      .clk_en  (clk_en)
   );

   function automatic int ratio_of(input int c);
      return (c < 6) ? (1 << c) : (1 << (c + 1));
   endfunction

   function automatic bit is_ratio(input int n);
      for (int c = 0; c < 8; c++) if (ratio_of(c) == n) return 1'b1;
      return 1'b0;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s got %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Edge-counting model of the requirements (R3, R4, R5)
   int ecount = 0;
   int cur_n  = 1;
   int prev_n = 1;
   int pend_n = 1;
   bit m_pend = 1'b0;
   bit exp_div = 1'b1;

   always @(posedge clk) begin
      if (rst_n) begin
         ecount++;
         if (m_pend && (ecount % ((cur_n > pend_n) ? cur_n : pend_n)) == 0) begin
            prev_n = cur_n;
            cur_n  = pend_n;
            m_pend = 1'b0;
         end
         if (cfg_wr) begin
            m_pend = 1'b1;
            pend_n = ratio_of(int'(cfg_sel));
         end
         exp_div = (cur_n == 1) ? 1'b1 : ((ecount % cur_n) < (cur_n / 2));
         #1;
         check(clk_en == ((ecount % cur_n) == 0), "R4/R5 clk_en", int'(clk_en),
               int'((ecount % cur_n) == 0));
         check(clk_div == exp_div, "R3/R5 clk_div high half", int'(clk_div), int'(exp_div));
      end
   end

   always @(negedge clk) begin
      if (rst_n && ecount > 0) begin
         #1;
         check(clk_div == ((cur_n == 1) ? 1'b0 : exp_div), "R3 clk_div low half",
               int'(clk_div), int'((cur_n == 1) ? 1'b0 : exp_div));
      end
   end

   // R6: half-cycle phase-length monitor
   int run = 0;
   bit have = 1'b0;
   bit last_s = 1'b0;
   always @(clk) begin
      if (rst_n && ecount > 0) begin
         bit s;
         int lo;
         #1;
         s  = clk_div;
         lo = (prev_n < cur_n) ? prev_n : cur_n;
         if (!have) begin
            have = 1'b1;
            run  = 1;
         end else if (s != last_s) begin
            check(run >= lo && is_ratio(run), "R6 phase length in half cycles", run, lo);
            run = 1;
         end else begin
            run++;
         end
         last_s = s;
      end
   end

   int cur_code = 0;

   task automatic do_write(input int code);
      @(posedge clk); #1;
      cfg_wr  = 1'b1;
      cfg_sel = 3'(code);
      @(posedge clk); #1;
      cfg_wr  = 1'b0;
   endtask

   task automatic wait_applied();
      do begin @(posedge clk); #1; end while (m_pend);
   endtask

   task automatic measure(output int per, output int hi);
      do begin @(posedge clk); #1; end while (!clk_en);
      per = 1;
      hi  = int'(clk_div);
      @(posedge clk); #1;
      while (!clk_en) begin
         per++;
         hi += int'(clk_div);
         @(posedge clk); #1;
      end
   endtask

   localparam int NVEC = 12;
   localparam int VEC [NVEC] = '{3, 0, 5, 7, 1, 6, 2, 4, 0, 7, 6, 3};

   initial begin
      #(4 * 190000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int per;
      int hi;
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check(clk_en == 1'b0, "R1 clk_en in reset", int'(clk_en), 0);
      check(clk_div == 1'b1, "R1 clk_div follows source high", int'(clk_div), 1);
      @(negedge clk); #1;
      check(clk_div == 1'b0, "R1 clk_div follows source low", int'(clk_div), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      measure(per, hi);
      check(per == 1, "R1 ratio after reset", per, 1);

      // R2/R3: vector table
      for (int i = 0; i < NVEC; i++) begin
         do_write(VEC[i]);
         wait_applied();
         cur_code = VEC[i];
         measure(per, hi);
         check(per == ratio_of(VEC[i]), "R2 period", per, ratio_of(VEC[i]));
         check(hi == ((ratio_of(VEC[i]) == 1) ? 1 : ratio_of(VEC[i]) / 2), "R3 high time",
               hi, (ratio_of(VEC[i]) == 1) ? 1 : ratio_of(VEC[i]) / 2);
      end

      // R5/R6: every ordered pair of distinct codes
      for (int a = 0; a < 8; a++) begin
         for (int b = 0; b < 8; b++) begin
            if (a != b) begin
               if (cur_code != a) begin
                  do_write(a);
                  wait_applied();
                  cur_code = a;
               end
               do_write(b);
               wait_applied();
               cur_code = b;
               measure(per, hi);
               check(per == ratio_of(b), "R6 pair period", per, ratio_of(b));
            end
         end
      end

      // R7: second write replaces a pending code
      do_write(5);
      wait_applied();
      do begin @(posedge clk); #1; end while ((ecount % 256) != 10);
      do_write(7);
      do_write(2);
      wait_applied();
      cur_code = 2;
      check(cur_n == 4, "R7 model ratio", cur_n, 4);
      measure(per, hi);
      check(per == 4, "R7 replaced code period", per, 4);

      // R8: select changes without the strobe are ignored
      for (int i = 0; i < 300; i++) begin
         @(posedge clk); #1;
         cfg_sel = 3'(i % 8);
      end
      measure(per, hi);
      check(per == 4, "R8 period after unstrobed select", per, 4);
      check(hi == 2, "R8 high time after unstrobed select", hi, 2);

      repeat (4) @(posedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule